// File: doc/BRIEF.md
# Debug Authentication Source Selector

This register block decides where each of four debug-enable signals comes from. For each signal it keeps an internal value bit and a source-selector bit. When the selector is clear, the system-wide enable follows an external input pin. When the selector is set, the enable follows the internal bit.

Software changes these bits through two write-only registers. One of them sets bits where a 1 is written. The other clears bits where a 1 is written. A read-only status register returns the effective enables and the effective selectors. Two further controls limit what software can change:
- Per-signal static disable straps pin a selector to the external source.
- A sticky lock bit, cleared only by power-on reset, freezes both the set and the clear paths.

Accesses use a simple valid/write/size/address/data port. Reads are combinational from the address. Writes take effect at the clock edge.

Top module: `dbg_auth_sel`

## Requirements
- R1: After power-on reset (`por_n` low), all selectors and internal value bits are 0 and the lock is 0. The status register therefore reads each value bit equal to its external input and each selector bit as 0.
- R2: For signal i, status bit 2i is the effective enable and bit 2i+1 is the effective selector. Signal order from bit 0 upward is: debug, non-invasive, secure invasive, secure non-invasive. When the effective selector of signal i is 0, `dbg_en_out[i]` equals `dbg_ext_in[i]`.
- R3: When the effective selector of signal i is 1, `dbg_en_out[i]` equals the internal value bit of signal i.
- R4: A word write to the set register (offset 0x004) sets every internal bit whose write-data bit is 1. Bit 2i is the value of signal i and bit 2i+1 is its selector. Bits written as 0 are unchanged.
- R5: A word write to the clear register (offset 0x008) clears every internal bit whose write-data bit is 1, using the same bit layout as the set register. If a set and a clear of the same bit coincide, the clear wins.
- R6: When `sel_disable[i]` is 1, selector i reads as 0 in status and the external input drives `dbg_en_out[i]`. The stored selector is not changed, and it applies again once the strap is released.
- R7: Bit 2 of the security control register (offset 0x00C) is the lock. Writing 1 to it sets the lock, writing 0 does not clear it, and only power-on reset clears it. While the lock is set, writes to the set and clear registers change nothing.
- R8: Only writes with `req_size` = 2 (32-bit) take effect. Byte (0) and halfword (1) writes are ignored.
- R9: The set and clear registers, status bits [31:8], and unmapped offsets read as zero. Writes to unmapped offsets change nothing.
- R10: `dbg_en_out` is combinational from `dbg_ext_in`, `sel_disable` and the stored state, so a pin change is visible in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| req_valid | input | 1 | Access valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | AW (12) | Byte offset |
| req_wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `req_addr`, combinational |
| dbg_ext_in | input | NSIG (4) | External enable inputs |
| sel_disable | input | NSIG (4) | Static straps forcing the external source |
| dbg_en_out | output | NSIG (4) | Effective system-wide enables |

## Verification
A write is registered at the clock edge where `req_valid` is high. The bench therefore drives each write at a falling edge and reads status at the next falling edge, one register stage later.

Reads and `dbg_en_out` are combinational. After changing `dbg_ext_in`, `sel_disable` or `req_addr`, the bench waits 1 ns and checks within the same cycle, with no clock edge in between. This same-cycle check is what confirms the R10 path.

The checks for ignored writes read the status or lock register back through `rdata` before the next write is issued.

// File: rtl/dbg_auth_sel.sv
module dbg_auth_sel #(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int NSIG = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NSIG-1:0] dbg_ext_in,
  input  logic [NSIG-1:0] sel_disable,
  output logic [NSIG-1:0] dbg_en_out
);
  localparam int SW = 2 * NSIG;
  localparam logic [AW-1:0] OFS_STAT = AW'(12'h000);
  localparam logic [AW-1:0] OFS_SET  = AW'(12'h004);
  localparam logic [AW-1:0] OFS_CLR  = AW'(12'h008);
  localparam logic [AW-1:0] OFS_SEC  = AW'(12'h00C);
  localparam int LOCK_BIT = 2;

  logic [NSIG-1:0] val_q, sel_q, sel_eff;
  logic [NSIG-1:0] w_val, w_sel;
  logic [SW-1:0]   stat;
  logic            lock_q;

  wire wr_ok  = req_valid && req_write && (req_size == 2'd2);
  wire wr_set = wr_ok && (req_addr == OFS_SET) && !lock_q;
  wire wr_clr = wr_ok && (req_addr == OFS_CLR) && !lock_q;
  wire wr_sec = wr_ok && (req_addr == OFS_SEC);

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    assign w_val[i]     = req_wdata[2*i];
    assign w_sel[i]     = req_wdata[2*i+1];
    assign stat[2*i]    = dbg_en_out[i];
    assign stat[2*i+1]  = sel_eff[i];
  end

  assign sel_eff    = sel_q & ~sel_disable;
  assign dbg_en_out = (sel_eff & val_q) | (~sel_eff & dbg_ext_in);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      val_q  <= '0;
      sel_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      val_q  <= (val_q | (wr_set ? w_val : '0)) & ~(wr_clr ? w_val : '0);
      sel_q  <= (sel_q | (wr_set ? w_sel : '0)) & ~(wr_clr ? w_sel : '0);
      if (wr_sec && req_wdata[LOCK_BIT]) lock_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (req_addr == OFS_STAT) rdata = {{(DW-SW){1'b0}}, stat};
    else if (req_addr == OFS_SEC) rdata[LOCK_BIT] = lock_q;
  end
endmodule

// File: rtl/dbg_auth_sel_chk.sv
module dbg_auth_sel_chk #(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int NSIG = 4
) (
  input logic            clk,
  input logic            por_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [1:0]      req_size,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic [DW-1:0]   rdata,
  input logic [NSIG-1:0] dbg_ext_in,
  input logic [NSIG-1:0] sel_disable,
  input logic [NSIG-1:0] dbg_en_out,
  input logic [NSIG-1:0] val_q,
  input logic [NSIG-1:0] sel_q,
  input logic            lock_q
);
  logic [NSIG-1:0] m_val;
  for (genvar i = 0; i < NSIG; i++) begin : g_m
    assign m_val[i] = req_wdata[2*i];
  end
  wire set_go = req_valid && req_write && req_size == 2'd2 && req_addr == AW'(4) && !lock_q;
  wire big_w  = req_valid && req_write && req_size != 2'd2;

  AST_EXT_WHEN_UNSEL: assert property (@(posedge clk) disable iff (!por_n)
    ((dbg_en_out ^ dbg_ext_in) & ~(sel_q & ~sel_disable)) == '0); // R2
  AST_STRAP_EXT: assert property (@(posedge clk) disable iff (!por_n)
    ((dbg_en_out ^ dbg_ext_in) & sel_disable) == '0); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> ($stable(val_q) && $stable(sel_q))); // R7
  AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    big_w |=> ($stable(val_q) && $stable(sel_q) && $stable(lock_q))); // R8
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (set_go && req_addr == AW'(4)) |=> ((val_q & $past(m_val)) == $past(m_val))); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    rdata[DW-1:2*NSIG] == '0); // R9
endmodule

bind dbg_auth_sel dbg_auth_sel_chk #(.AW(AW), .DW(DW), .NSIG(NSIG)) u_chk (
  .clk(clk), .por_n(por_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata),
  .dbg_ext_in(dbg_ext_in), .sel_disable(sel_disable), .dbg_en_out(dbg_en_out),
  .val_q(val_q), .sel_q(sel_q), .lock_q(lock_q)
);

// File: tb/tb_dbg_auth_sel.sv
module tb_dbg_auth_sel;
  logic        clk = 0, por_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_size = 2'd2;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rdata;
  logic [3:0]  dbg_ext_in = '0, sel_disable = '0, dbg_en_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbg_auth_sel dut (.*);

  // {addr, wdata[7:0], ext, strap, exp_status, exp_eff}
  localparam logic [39:0] VEC [8] = '{
    {12'h004, 8'h03, 4'b0000, 4'b0000, 8'h03, 4'b0001},
    {12'h004, 8'h08, 4'b0010, 4'b0000, 8'h0B, 4'b0001},
    {12'h008, 8'h01, 4'b0011, 4'b0000, 8'h0A, 4'b0000},
    {12'h004, 8'hF0, 4'b0000, 4'b0000, 8'hFA, 4'b1100},
    {12'h004, 8'h00, 4'b1111, 4'b0000, 8'hFA, 4'b1100},
    {12'h008, 8'h20, 4'b0000, 4'b0000, 8'hCA, 4'b1000},
    {12'h010, 8'hFF, 4'b0000, 4'b1000, 8'h0A, 4'b0000},
    {12'h010, 8'hFF, 4'b0000, 4'b0000, 8'hCA, 4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_size = 2'd2;
  endtask

  task automatic rd_stat(input string req, input logic [7:0] es, input logic [3:0] ee);
    req_addr = 12'h000; #1;
    chk(req, rdata, {24'h0, es});
    chk(req, {28'h0, dbg_en_out}, {28'h0, ee});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dbg_ext_in = 4'b0101;
    repeat (3) @(negedge clk);
    por_n = 1;
    rd_stat("R1 reset status", 8'h11, 4'b0101);
    req_addr = 12'h00C; #1;
    chk("R1 lock reset", rdata, 32'h0);
    dbg_ext_in = 4'b0000;

    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][39:28], {24'h0, VEC[k][27:20]}, 2'd2);
      dbg_ext_in = VEC[k][19:16]; sel_disable = VEC[k][15:12];
      rd_stat($sformatf("R2 R3 R4 R5 R6 R9 vec%0d", k), VEC[k][11:4], VEC[k][3:0]);
    end

    // R10: same-cycle pin propagation on signal 2 (selector clear)
    dbg_ext_in = 4'b0100; #1;
    chk("R10 comb path", {28'h0, dbg_en_out}, 32'hC);
    dbg_ext_in = 4'b0000; #1;

    // R9: set/clear/unmapped read zero
    req_addr = 12'h004; #1; chk("R9 set reads 0", rdata, 0);
    req_addr = 12'h008; #1; chk("R9 clr reads 0", rdata, 0);
    req_addr = 12'h100; #1; chk("R9 unmapped 0", rdata, 0);

    // R8: byte and halfword writes ignored
    wr(12'h004, 32'hFF, 2'd0);
    rd_stat("R8 byte ignored", 8'hCA, 4'b1000);
    wr(12'h008, 32'hFF, 2'd1);
    rd_stat("R8 half ignored", 8'hCA, 4'b1000);
    wr(12'h00C, 32'h4, 2'd1);
    req_addr = 12'h00C; #1; chk("R8 lock half ignored", rdata, 0);

    // R7: lock
    wr(12'h00C, 32'h4, 2'd2);
    req_addr = 12'h00C; #1; chk("R7 lock set", rdata, 32'h4);
    wr(12'h004, 32'hFF, 2'd2);
    rd_stat("R7 set blocked", 8'hCA, 4'b1000);
    wr(12'h008, 32'hFF, 2'd2);
    rd_stat("R7 clr blocked", 8'hCA, 4'b1000);
    wr(12'h00C, 32'h0, 2'd2);
    req_addr = 12'h00C; #1; chk("R7 lock sticky", rdata, 32'h4);

    // R1: power-on reset clears lock and state
    por_n = 0; #1; por_n = 1; dbg_ext_in = 4'b1010;
    rd_stat("R1 re-reset", 8'h44, 4'b1010);
    req_addr = 12'h00C; #1; chk("R1 lock cleared", rdata, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule